// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Gate

This block is the host-bus register logic of a two-channel IDE adapter. It decodes a host address with separate read and write strobes. It produces chip selects and a three-bit register index for each channel's task-file window and alternate-status register. It also merges the two raw drive interrupts into one host interrupt line.

Each channel has one interrupt-enable latch, and the latch has no data bits. Any write to the channel's mask address sets the latch. A read of that same address clears it. The host line is asserted only while a channel is enabled and its drive is requesting. A status address returns the raw drive request on bit 0 whether or not the channel is enabled.

A slot-select register picks the channel that receives the DMA request/acknowledge pair and selects the alternate fast address space. A strapped four-bit card-type code can be read back one bit per byte.

Top module: `ide_irq_gate`

## Requirements
- R1: After reset both interrupt enables and the slot-select register are 0. `irq_host` stays 0 even with both drive requests high, and `dma_chan`, `fast_space` and a read of address 0x000 all return 0.
- R2: A write of any data to 0x880 (channel 0) or 0xC80 (channel 1) sets that channel's enable from the next clock onward.
- R3: A read of 0x880 or 0xC80 without a write clears that channel's enable from the next clock onward. The read data is 0.
- R4: When read and write strobes hit the same mask address in one cycle, the enable is set.
- R5: `irq_host` is the OR, over both channels, of the enable ANDed with that channel's raw drive request, and it is combinational in the request.
- R6: A read of 0x8A4 (channel 0) or 0xCA4 (channel 1) returns the raw drive request in bit 0, independent of the enable, with all other bits 0.
- R7: During a strobe, address 0x800+16*i or 0xC00+16*i (i = 0..7, address bits [3:0] zero) asserts `cs_task` bit 0 or bit 1 respectively, with `reg_idx` = address bits [6:4]. With no strobe, or any other address, `cs_task` is 0.
- R8: During a strobe, 0x8E0 asserts `cs_ctrl` bit 0 and 0xCE0 asserts `cs_ctrl` bit 1. `cs_task` and `cs_ctrl` are never active together.
- R9: A read of 0x2280, 0x2284, 0x2288 or 0x228C returns card-type bit 0, 1, 2 or 3 respectively in bit 0, with the other bits 0. The four bits assemble, least significant bit first, to the default code 3.
- R10: A write to 0x000 loads data bit 0 into `dma_chan` and data bit 5 into `fast_space`. A read of 0x000 returns them at the same positions, and writing 0 restores both to 0.
- R11: Reads and writes to any other address leave both enables and the slot-select register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 14 | Host byte address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| drv_irq | input | 2 | Raw drive interrupt requests, bit per channel |
| irq_host | output | 1 | Combined host interrupt |
| cs_task | output | 2 | Task-file chip select per channel |
| cs_ctrl | output | 2 | Alternate-status/control select per channel |
| reg_idx | output | 3 | Task-file register index |
| dma_chan | output | 1 | Channel receiving the DMA request/acknowledge |
| fast_space | output | 1 | Alternate fast address space selected |

## Verification
An enable latch stuck or flipped shows on `irq_host` at the first clock edge after the offending mask access, and only while that channel's drive is requesting. The bench therefore holds each drive request high while it probes the latches. A wrong slot-select value appears at once on `dma_chan`, `fast_space` and the 0x000 readback. Decode faults show in the same cycle as the strobe, on the chip selects, on the index or on the read data.

// File: rtl/ide_irq_gate.sv
module ide_irq_gate #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter logic [3:0] CARD_TYPE = 4'd3,
  parameter logic [13:0] CH0_BASE = 14'h0800,
  parameter logic [13:0] CH1_BASE = 14'h0C00,
  parameter logic [13:0] IDENT_BASE = 14'h2280,
  parameter logic [13:0] SEL_ADDR = 14'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [1:0]        drv_irq,
  output logic              irq_host,
  output logic [1:0]        cs_task,
  output logic [1:0]        cs_ctrl,
  output logic [2:0]        reg_idx,
  output logic              dma_chan,
  output logic              fast_space
);
  localparam int NCH = 2;
  localparam logic [ADDR_W-1:0] MASK_OFS = ADDR_W'(14'h080);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(14'h0A4);
  localparam logic [ADDR_W-1:0] ALT_OFS  = ADDR_W'(14'h0E0);

  logic access;
  logic [NCH-1:0] en, mask_hit, stat_hit;
  logic sel_hit, id_hit;
  logic sel_dma_q, sel_fast_q;

  assign access = rd | wr;
  assign reg_idx = addr[6:4];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = (c == 0) ? ADDR_W'(CH0_BASE) : ADDR_W'(CH1_BASE);
    logic en_q;

    assign mask_hit[c] = (addr == BASE + MASK_OFS);
    assign stat_hit[c] = (addr == BASE + STAT_OFS);
    assign cs_task[c]  = access && (addr[ADDR_W-1:7] == BASE[ADDR_W-1:7]) && (addr[3:0] == 4'd0);
    assign cs_ctrl[c]  = access && (addr == BASE + ALT_OFS);

    always_ff @(posedge clk) begin
      if (!rst_n)                    en_q <= 1'b0;
      else if (wr && mask_hit[c])    en_q <= 1'b1;
      else if (rd && mask_hit[c])    en_q <= 1'b0;
    end
    assign en[c] = en_q;

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && mask_hit[c]) |=> en[c]);
    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr && mask_hit[c]) |=> !en[c]);
  end

  assign irq_host = |(en & drv_irq);

  assign sel_hit = (addr == ADDR_W'(SEL_ADDR));
  assign id_hit  = (addr[ADDR_W-1:4] == IDENT_BASE[ADDR_W-1:4]) && (addr[1:0] == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_dma_q  <= 1'b0;
      sel_fast_q <= 1'b0;
    end else if (wr && sel_hit) begin
      sel_dma_q  <= wdata[0];
      sel_fast_q <= wdata[5];
    end
  end
  assign dma_chan   = sel_dma_q;
  assign fast_space = sel_fast_q;

  always_comb begin
    rdata = '0;
    if (sel_hit) begin
      rdata[0] = sel_dma_q;
      rdata[5] = sel_fast_q;
    end else if (stat_hit[0]) rdata[0] = drv_irq[0];
    else if (stat_hit[1])     rdata[0] = drv_irq[1];
    else if (id_hit)          rdata[0] = CARD_TYPE[addr[3:2]];
  end

  // R8
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_task, cs_ctrl}));
  // R10
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_hit) |=> (dma_chan == $past(wdata[0])) && (fast_space == $past(wdata[5])));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mask_hit[0] || mask_hit[1] || sel_hit) |=> $stable(en) && $stable(dma_chan) && $stable(fast_space));
  // R5
  no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_irq == 2'b00) |-> !irq_host);
endmodule

// File: tb/sim_ide_irq_gate.sv
`timescale 1ns/1ps
module sim_ide_irq_gate;
  logic clk = 0, rst_n = 0;
  logic [13:0] addr = '0;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] drv_irq = '0, cs_task, cs_ctrl;
  logic irq_host, dma_chan, fast_space;
  logic [2:0] reg_idx;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  ide_irq_gate u0 (.clk, .rst_n, .addr, .rd, .wr, .wdata, .rdata, .drv_irq,
    .irq_host, .cs_task, .cs_ctrl, .reg_idx, .dma_chan, .fast_space);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [13:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0; addr = 14'h3FF0;
  endtask

  task automatic bus_rd(logic [13:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #2 d = rdata;
    @(negedge clk); rd = 0; addr = 14'h3FF0;
  endtask

  task automatic irq_seen(string req, logic [1:0] req_in, logic exp);
    drv_irq = req_in; #1 chk(req, irq_host, exp);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    irq_seen("R1", 2'b11, 1'b0);
    chk("R1", {dma_chan, fast_space}, 0);
    bus_rd(14'h000, d); chk("R1", d, 0);
  endtask

  task automatic t_enable;
    logic [7:0] d;
    bus_wr(14'h880, 8'h5A);
    irq_seen("R2", 2'b01, 1'b1);
    irq_seen("R5", 2'b10, 1'b0);
    bus_wr(14'hC80, 8'h00);
    irq_seen("R2", 2'b10, 1'b1);
    irq_seen("R5", 2'b00, 1'b0);
    bus_rd(14'h880, d); chk("R3", d, 0);
    irq_seen("R3", 2'b01, 1'b0);
    irq_seen("R5", 2'b11, 1'b1);
    bus_rd(14'hC80, d);
    irq_seen("R3", 2'b11, 1'b0);
  endtask

  task automatic t_simul;
    logic [7:0] d;
    @(negedge clk); addr = 14'hC80; rd = 1; wr = 1;
    @(negedge clk); rd = 0; wr = 0; addr = 14'h3FF0;
    irq_seen("R4", 2'b10, 1'b1);
    bus_rd(14'hC80, d);
    irq_seen("R4", 2'b10, 1'b0);
  endtask

  task automatic t_status;
    logic [7:0] d;
    drv_irq = 2'b11;
    bus_rd(14'h8A4, d); chk("R6", d, 8'h01);
    bus_rd(14'hCA4, d); chk("R6", d, 8'h01);
    drv_irq = 2'b10;
    bus_rd(14'h8A4, d); chk("R6", d, 8'h00);
    bus_rd(14'hCA4, d); chk("R6", d, 8'h01);
    drv_irq = 2'b00;
  endtask

  task automatic t_task;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); addr = 14'h800 + 14'(16*i); rd = 1;
      #1 chk("R7", {cs_task, reg_idx}, {2'b01, 3'(i)});
      rd = 0; wr = 1; addr = 14'hC00 + 14'(16*i); wdata = 8'hFF;
      #1 chk("R7", {cs_task, reg_idx}, {2'b10, 3'(i)});
      wr = 0; #1 chk("R7", cs_task, 0);
    end
    @(negedge clk); addr = 14'h804; rd = 1; #1 chk("R7", cs_task, 0);
    rd = 0; addr = 14'h3FF0;
    chk("R10", dma_chan, 0);
  endtask

  task automatic t_ctrl;
    @(negedge clk); addr = 14'h8E0; rd = 1;
    #1 chk("R8", {cs_task, cs_ctrl}, 4'b0001);
    addr = 14'hCE0; #1 chk("R8", {cs_task, cs_ctrl}, 4'b0010);
    rd = 0; #1 chk("R8", cs_ctrl, 0);
    addr = 14'h3FF0;
  endtask

  task automatic t_ident;
    logic [7:0] d;
    logic [3:0] code;
    for (int k = 0; k < 4; k++) begin
      bus_rd(14'h2280 + 14'(4*k), d);
      chk("R9", d[7:1], 0);
      code[k] = d[0];
    end
    chk("R9", code, 4'd3);
  endtask

  task automatic t_select;
    logic [7:0] d;
    bus_wr(14'h000, 8'h21);
    chk("R10", {dma_chan, fast_space}, 2'b11);
    bus_rd(14'h000, d); chk("R10", d, 8'h21);
    bus_wr(14'h000, 8'hDE);
    chk("R10", {dma_chan, fast_space}, 2'b00);
    bus_wr(14'h000, 8'h01);
    chk("R10", {dma_chan, fast_space}, 2'b10);
    bus_wr(14'h000, 8'h00);
    chk("R10", {dma_chan, fast_space}, 2'b00);
  endtask

  task automatic t_other;
    logic [7:0] d;
    bus_wr(14'h000, 8'h01);
    bus_wr(14'h880, 8'h00);
    bus_rd(14'h884, d); bus_rd(14'h881, d); bus_rd(14'hC84, d);
    bus_wr(14'h001, 8'h00); bus_wr(14'h8A4, 8'h00); bus_wr(14'hC81, 8'h00);
    irq_seen("R11", 2'b01, 1'b1);
    chk("R11", dma_chan, 1);
    irq_seen("R11", 2'b10, 1'b0);
    drv_irq = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drv_irq = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_enable;
    t_simul;
    t_status;
    t_task;
    t_ctrl;
    t_ident;
    t_select;
    t_other;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule